// File: doc/BRIEF.md
# Die Heater Contrast Controller

This block decides when to warm the sensing die so that a faint image regains contrast. Once per frame the sensor reports a 4-bit code for the die temperature change, where 8 means no change and each step up or down is 1.4 K. The two end codes, 0 and 15, are saturated readings: they only bound the magnitude of the change.

When the system raises a low-contrast request, the controller waits for the next frame strobe and records the code seen there as its starting point. It then holds the heater enable high until a frame reports a code at least two steps above that start. Heating also ends if a programmed number of frames passes without reaching that rise. A request that starts at the top saturated code ends at once and never heats. A nap request always forces the heater off and drops any cycle in progress. A status code reports the state of the controller, so that the system can retry or give up.

Top module: `die_heat_ctl`

## Requirements
- R1: While reset is asserted and after it is released, status is 0 (idle) and heater_en is low.
- R2: With low_contrast high in idle, the next frame_done whose temp_code is not 15 records that code as the start. From the clock edge that samples this strobe, status is 1 (heating) and heater_en is high. Before that strobe, status stays 0.
- R3: While heating, the first frame_done whose temp_code is at least start + 2 ends the cycle. From that edge, status is 2 (done) and heater_en is low. A code of start + 1 keeps heating.
- R4: While heating, a temp_code of 15 (top saturation) counts as the target reached, even when start + 2 exceeds 15. A temp_code of 0 never counts as reached.
- R5: If the recorded starting code is 15, status becomes 4 (saturated) at that edge and heater_en never rises.
- R6: The value of timeout_frames is latched when the start is recorded. If frame number N after the start (N = that latched value) does not reach the target, status becomes 3 (timeout) and heater_en falls. Reaching the target on frame N gives done instead.
- R7: heater_en is low in any cycle in which nap_req is high. At the next edge the status returns to 0 and any pending or running cycle is abandoned.
- R8: The statuses done, timeout and saturated hold while low_contrast stays high. They return to 0 at the first edge that samples low_contrast low. A later request records a fresh start.
- R9: frame_done in idle without a request has no effect. A change of timeout_frames after the start is recorded has no effect on when the timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe: temp_code holds this frame's temperature code |
| temp_code | input | 4 | Latched temperature-change code, 8 = no change, 1.4 K per step |
| low_contrast | input | 1 | Request to restore contrast by heating |
| nap_req | input | 1 | Nap request; forces the heater off |
| timeout_frames | input | TMO_W (8) | Frame budget for one heat cycle |
| heater_en | output | 1 | Heater enable, high draws heater current |
| status | output | 3 | 0 idle, 1 heating, 2 done, 3 timeout, 4 saturated |

## Verification
The hardest cases to reach are the ones where two outcomes fall on the same frame. On the budget frame itself, reaching the target must win over the timeout. A top-saturated code must end the cycle even when the numeric target lies above 15. The stimulus builds these cases on purpose: it picks a start code and a budget, then counts frames so that the deciding frame carries the chosen code. The timeout input is also changed in the middle of a cycle, to show that the latched budget is the one that counts. A nap is raised in the middle of a cycle, and the heater is sampled before the clock edge as well as after it.

// File: rtl/die_heat_pkg.sv
package die_heat_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HEAT = 3'd1,
    ST_DONE = 3'd2,
    ST_TOUT = 3'd3,
    ST_SAT  = 3'd4,
    ST_ARM  = 3'd5
  } heat_state_t;

  function automatic logic f_top_sat(input logic [CODE_W-1:0] c);
    return c == CODE_TOP;
  endfunction

  function automatic logic f_reached(input logic [CODE_W-1:0] start,
                                     input logic [CODE_W-1:0] cur,
                                     input int unsigned rise);
    logic [CODE_W+1:0] goal;
    goal = {2'b00, start} + (CODE_W+2)'(rise);
    return f_top_sat(cur) || ({2'b00, cur} >= goal);
  endfunction

  function automatic logic [2:0] f_status(input heat_state_t s);
    return (s == ST_ARM) ? 3'd0 : 3'(s);
  endfunction
endpackage

// File: rtl/die_heat_start.sv
module die_heat_start
  import die_heat_pkg::*;
#(
  parameter int RISE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] temp_code,
  output logic              reached
);
  logic [CODE_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       start_q <= '0;
    else if (capture) start_q <= temp_code;
  end

  assign reached = f_reached(start_q, temp_code, RISE);
endmodule

// File: rtl/die_heat_timer.sv
module die_heat_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit_in,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q, lim_q;
  logic [TMO_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign expired  = tick && (next_cnt >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (capture) begin
      cnt_q <= '0;
      lim_q <= limit_in;
    end else if (tick && !next_cnt[TMO_W]) begin
      cnt_q <= next_cnt[TMO_W-1:0];
    end
  end
endmodule

// File: rtl/die_heat_seq.sv
module die_heat_seq
  import die_heat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [CODE_W-1:0] temp_code,
  input  logic              low_contrast,
  input  logic              nap_req,
  input  logic              reached,
  input  logic              expired,
  output logic              capture,
  output logic              tick,
  output heat_state_t       state
);
  heat_state_t nxt;

  assign capture = (state == ST_ARM) && frame_done && !nap_req && !f_top_sat(temp_code);
  assign tick    = (state == ST_HEAT) && frame_done && !nap_req;

  always_comb begin
    nxt = state;
    if (nap_req) nxt = ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (low_contrast) nxt = ST_ARM;
        ST_ARM:  if (frame_done) nxt = f_top_sat(temp_code) ? ST_SAT : ST_HEAT;
        ST_HEAT: if (frame_done) begin
          if (reached)      nxt = ST_DONE;
          else if (expired) nxt = ST_TOUT;
        end
        default: if (!low_contrast) nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/die_heat_ctl.sv
module die_heat_ctl
  import die_heat_pkg::*;
#(
  parameter int TMO_W = 8,
  parameter int RISE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [3:0]       temp_code,
  input  logic             low_contrast,
  input  logic             nap_req,
  input  logic [TMO_W-1:0] timeout_frames,
  output logic             heater_en,
  output logic [2:0]       status
);
  logic        capture, tick, reached, expired;
  heat_state_t state;

  die_heat_seq u_seq (
    .clk, .rst_n, .frame_done, .temp_code, .low_contrast, .nap_req,
    .reached, .expired, .capture, .tick, .state
  );

  die_heat_start #(.RISE(RISE)) u_start (
    .clk, .rst_n, .capture, .temp_code, .reached
  );

  die_heat_timer #(.TMO_W(TMO_W)) u_timer (
    .clk, .rst_n, .capture, .tick, .limit_in(timeout_frames), .expired
  );

  assign heater_en = (state == ST_HEAT) && !nap_req;
  assign status    = f_status(state);
endmodule

// File: rtl/die_heat_chk.sv
module die_heat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_done,
  input logic [3:0] temp_code,
  input logic       nap_req,
  input logic       heater_en,
  input logic [2:0] status
);
  p_nap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nap_req |=> status == 3'd0);

  p_heat_only_heating_r2: assert property (@(posedge clk) disable iff (!rst_n)
    heater_en |-> status == 3'd1);

  p_heat_rise_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(heater_en) |-> $past(frame_done));

  p_done_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd2 && $past(status) == 3'd1) |-> $past(frame_done));

  p_sat_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4 && $past(status) != 3'd4) |-> ($past(frame_done) && $past(temp_code) == 4'hF));

  p_tout_on_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd3 && $past(status) == 3'd1) |-> $past(frame_done));

  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd4);
endmodule

bind die_heat_ctl die_heat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .temp_code(temp_code),
  .nap_req(nap_req), .heater_en(heater_en), .status(status)
);

// File: tb/test_die_heat_ctl.sv
module test_die_heat_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, frame_done = 0, low_contrast = 0, nap_req = 0;
  logic [3:0] temp_code = 4'd8;
  logic [7:0] timeout_frames = 8'd10;
  logic       heater_en;
  logic [2:0] status;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  typedef struct { logic [2:0] st; logic ht; string tag; } exp_t;
  exp_t q[$];

  // bench model: 0 idle, 5 armed, 1 heating, 2 done, 3 timeout, 4 saturated
  int m_st = 0, m_start = 0, m_k = 0, m_lim = 0;

  die_heat_ctl i_die_heat_ctl (
    .clk, .rst_n, .frame_done, .temp_code, .low_contrast, .nap_req,
    .timeout_frames, .heater_en, .status
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [2:0] st, input logic ht,
                       input logic [2:0] e_st, input logic e_ht, input string tag);
    n_chk++;
    if (st !== e_st || ht !== e_ht) begin
      n_fail++;
      $display("FAIL %s: status=%0d heater=%0b expected status=%0d heater=%0b",
               tag, st, ht, e_st, e_ht);
    end
  endtask

  task automatic step(input bit fd, input int code, input bit lc, input bit nap,
                      input int tmo, input string tag);
    exp_t e;
    @(negedge clk);
    frame_done = fd; temp_code = 4'(code); low_contrast = lc;
    nap_req = nap; timeout_frames = 8'(tmo);
    if (nap) begin
      #1 check(status, heater_en, status, 1'b0, {tag, " same-cycle nap"});
    end
    if (nap) m_st = 0;
    else if (m_st == 0) begin if (lc) m_st = 5; end
    else if (m_st == 5) begin
      if (fd) begin
        if (code == 15) m_st = 4;
        else begin m_st = 1; m_start = code; m_k = 0; m_lim = tmo; end
      end
    end else if (m_st == 1) begin
      if (fd) begin
        m_k++;
        if (code == 15 || code >= m_start + 2) m_st = 2;
        else if (m_k >= m_lim) m_st = 3;
      end
    end else if (!lc) m_st = 0;
    e.st = (m_st == 5) ? 3'd0 : 3'(m_st);
    e.ht = (m_st == 1) && !nap;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(status, heater_en, e.st, e.ht, e.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(status, heater_en, 3'd0, 1'b0, "R1 in reset");
    rst_n = 1;
    step(0, 8, 0, 0, 10, "R1 after reset");
    // R9: frames without request do nothing
    step(1, 8, 0, 0, 10, "R9 idle frame");
    step(1, 3, 0, 0, 10, "R9 idle frame");
    // R2, R3 basic rise 8 -> 10
    step(0, 8, 1, 0, 10, "R2 armed");
    step(0, 8, 1, 0, 10, "R2 armed wait");
    step(1, 8, 1, 0, 10, "R2 start capture");
    step(0, 8, 1, 0, 10, "R2 heating");
    step(1, 9, 1, 0, 10, "R3 one step keeps heating");
    step(1, 10, 1, 0, 10, "R3 two steps done");
    step(1, 12, 1, 0, 10, "R8 done holds");
    step(0, 8, 0, 0, 10, "R8 release");
    // R4: start 14, saturated 15 counts as reached
    step(0, 8, 1, 0, 10, "R4 arm");
    step(1, 14, 1, 0, 10, "R4 start 14");
    step(1, 14, 1, 0, 10, "R4 still heating");
    step(1, 15, 1, 0, 10, "R4 top saturation done");
    step(0, 8, 0, 0, 10, "R8 release");
    // R6 timeout, R4 code 0, R9 timeout input change
    step(0, 8, 1, 0, 3, "R6 arm");
    step(1, 3, 1, 0, 3, "R6 start 3 budget 3");
    step(1, 0, 1, 0, 3, "R4 code 0 not reached");
    step(1, 4, 1, 0, 100, "R9 budget change ignored");
    step(1, 4, 1, 0, 100, "R6 timeout on frame 3");
    step(0, 4, 1, 0, 100, "R8 timeout holds");
    step(0, 8, 0, 0, 10, "R8 release");
    // R6: reached on budget frame wins
    step(0, 8, 1, 0, 2, "R6 arm");
    step(1, 5, 1, 0, 2, "R6 start 5 budget 2");
    step(1, 6, 1, 0, 2, "R6 frame 1");
    step(1, 7, 1, 0, 2, "R6 reach on budget frame");
    step(0, 8, 0, 0, 10, "R8 release");
    // R5 start at 15
    step(0, 8, 1, 0, 10, "R5 arm");
    step(1, 15, 1, 0, 10, "R5 saturated start");
    step(1, 8, 1, 0, 10, "R5 stays saturated");
    step(0, 8, 0, 0, 10, "R8 release");
    // R7 nap during heating, then R8 fresh start
    step(0, 8, 1, 0, 10, "R7 arm");
    step(1, 6, 1, 0, 10, "R7 heating");
    step(0, 6, 1, 1, 10, "R7 nap abort");
    step(1, 8, 1, 1, 10, "R7 nap blocks frame");
    step(0, 8, 1, 0, 10, "R8 rearm");
    step(1, 9, 1, 0, 10, "R8 fresh start 9");
    step(1, 10, 1, 0, 10, "R8 one step from fresh start");
    step(1, 11, 1, 0, 10, "R8 done from fresh start");
    step(0, 8, 0, 0, 10, "R8 release");
    step(0, 8, 0, 0, 10, "R1 idle");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule